// File: doc/BRIEF.md
# Pseudo-SRAM Sleep and Configuration Sequencer

This block runs on the host side of an asynchronous pseudo-SRAM. It owns the memory's active-low sleep pin and carries out three jobs: writing the memory's configuration register, putting the memory to sleep, and waking it again. The new register value is sent on the address lines during a short low pulse on the sleep pin. Chip enable is held high for the whole sequence.

The memory has one sleep pin but two kinds of sleep. The sequencer keeps a shadow copy of the register, and one stored bit decides which kind of sleep a sleep command gives. If that bit is set, the memory keeps part of its array refreshed. If it is clear, the memory powers down fully and loses its contents. After a full power-down the sequencer waits out the long re-initialisation time, and it also resets its shadow copy, because the memory has reloaded its own default.

Outside a sequence, the access controller's chip enable and address pass straight through to the memory. Access requests get a grant only when the memory is awake and the sequencer is idle. A page-enable flag taken from the shadow copy tells the access controller whether page-mode reads are allowed.

Top module: `psram_sleep_seq`

## Requirements
- R1: After reset, `status` is 0 (active), `mem_zz_n` is 1, `lost` is 0, `dq_hiz` is 0, and `cfg_shadow` equals `CFG_DEFAULT`. The `status` encoding is: 0 active, 1 partial refresh, 2 deep power-down, 3 busy.
- R2: `page_en` always equals bit `PAGE_BIT` of `cfg_shadow`. `cfg_shadow` takes the loaded value when a load sequence completes.
- R3: `mem_ce_n` is 1 in every cycle in which the sequencer is not idle and active. This includes every cycle in which `mem_zz_n` is 0.
- R4: An accepted load command produces the following sequence:
  - `mem_addr` shows the command value for `SETUP_CYC` cycles with `mem_zz_n` high.
  - `mem_zz_n` is then low for `PULSE_CYC` cycles.
  - It is then high for `HOLD_CYC` cycles, with the address unchanged.
  - `status` is 3 for exactly `SETUP_CYC+PULSE_CYC+HOLD_CYC` cycles.
- R5: An accepted sleep command drives `mem_zz_n` low until wake. The resulting state depends on bit `MODE_BIT` of `cfg_shadow`:
  - If the bit is 1, `status` becomes 1.
  - If the bit is 0, `status` becomes 2 and `lost` is set. `lost` then stays set until reset.
- R6: An accepted wake command raises `mem_zz_n` and holds `status` at 3 while the exit wait runs. The wait lasts `PAR_EXIT_CYC` cycles after partial refresh and `DPD_EXIT_CYC` cycles after deep power-down. A deep power-down exit also resets `cfg_shadow` to `CFG_DEFAULT`.
- R7: `acc_gnt` is high only when `acc_req` is high, `status` is 0 and `cmd_valid` is low. While `status` is 0, `mem_addr` equals `acc_addr` and `mem_ce_n` equals `acc_ce_n`.
- R8: `dq_hiz` is 1 whenever `status` is not 0.
- R9: Command codes on `cmd_op` are 0 load, 1 sleep, 2 wake and 3 none. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high while active or asleep and low while busy.
- R10: Commands that do not fit the current state have no effect on `status`, `cfg_shadow` or `mem_zz_n`. These are load or sleep while asleep, and wake or none while active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (0 load, 1 sleep, 2 wake, 3 none) |
| cmd_cfg | input | AW | Register value for a load |
| cmd_ready | output | 1 | Command can be taken |
| acc_req | input | 1 | Access controller requests the bus |
| acc_ce_n | input | 1 | Access controller chip enable |
| acc_addr | input | AW | Access controller address |
| acc_gnt | output | 1 | Access allowed this cycle |
| mem_addr | output | AW | Address lines to the memory |
| mem_ce_n | output | 1 | Chip enable to the memory |
| mem_zz_n | output | 1 | Sleep-enable pin to the memory |
| dq_hiz | output | 1 | Data pins must float |
| page_en | output | 1 | Page-mode reads permitted |
| cfg_shadow | output | AW | Shadow copy of the configuration register |
| status | output | 2 | 0 active, 1 partial refresh, 2 deep power-down, 3 busy |
| lost | output | 1 | Memory contents lost since reset |

## Verification
The bench builds the block with setup, pulse and hold lengths of 2, 3 and 2 cycles and a partial-refresh exit of 4 cycles. It shortens the deep power-down exit to 40 cycles, so a full power-down, its exit wait and the reload of the register default all fit in one short run. The default value sets the mode bit and clears the page bit. Loads with the page bit set and with the mode bit cleared therefore change both outputs and reach both kinds of sleep.

// File: rtl/psram_sleep_seq.sv
module psram_sleep_seq #(
  parameter int AW = 18,
  parameter logic [AW-1:0] CFG_DEFAULT = 18'h00010,
  parameter int MODE_BIT = 4,
  parameter int PAGE_BIT = 7,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC = 2,
  parameter int PAR_EXIT_CYC = 4,
  parameter int DPD_EXIT_CYC = 37500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_cfg,
  output logic          cmd_ready,
  input  logic          acc_req,
  input  logic          acc_ce_n,
  input  logic [AW-1:0] acc_addr,
  output logic          acc_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_zz_n,
  output logic          dq_hiz,
  output logic          page_en,
  output logic [AW-1:0] cfg_shadow,
  output logic [1:0]    status,
  output logic          lost
);
  localparam int MA = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MB = (HOLD_CYC > PAR_EXIT_CYC) ? HOLD_CYC : PAR_EXIT_CYC;
  localparam int MC = (MA > MB) ? MA : MB;
  localparam int MX = (MC > DPD_EXIT_CYC) ? MC : DPD_EXIT_CYC;
  localparam int CW = $clog2(MX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LSU, S_LPW, S_LHD, S_SLP, S_EXIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] hold_q;
  logic          deep_q;
  logic          take;

  assign cmd_ready = (st == S_IDLE) || (st == S_SLP);
  assign take      = cmd_valid && cmd_ready;
  assign acc_gnt   = acc_req && (st == S_IDLE) && !cmd_valid;
  assign mem_addr  = (st == S_IDLE) ? acc_addr : hold_q;
  assign mem_ce_n  = (st == S_IDLE) ? acc_ce_n : 1'b1;
  assign mem_zz_n  = !((st == S_LPW) || (st == S_SLP));
  assign dq_hiz    = (st != S_IDLE);
  assign page_en   = cfg_shadow[PAGE_BIT];
  assign status    = (st == S_IDLE) ? 2'd0 :
                     (st == S_SLP)  ? (deep_q ? 2'd2 : 2'd1) : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      hold_q     <= '0;
      deep_q     <= 1'b0;
      cfg_shadow <= CFG_DEFAULT;
      lost       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take && cmd_op == 2'd0) begin
          st     <= S_LSU;
          cnt    <= CW'(SETUP_CYC - 1);
          hold_q <= cmd_cfg;
        end else if (take && cmd_op == 2'd1) begin
          st     <= S_SLP;
          deep_q <= !cfg_shadow[MODE_BIT];
          if (!cfg_shadow[MODE_BIT]) lost <= 1'b1;
        end
        S_LSU: if (cnt == '0) begin
          st  <= S_LPW;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_LPW: if (cnt == '0) begin
          st         <= S_LHD;
          cnt        <= CW'(HOLD_CYC - 1);
          cfg_shadow <= hold_q;
        end else cnt <= cnt - 1'b1;
        S_LHD: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_SLP: if (take && cmd_op == 2'd2) begin
          st  <= S_EXIT;
          cnt <= deep_q ? CW'(DPD_EXIT_CYC - 1) : CW'(PAR_EXIT_CYC - 1);
          if (deep_q) cfg_shadow <= CFG_DEFAULT;
        end
        S_EXIT: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psram_sleep_seq_chk.sv
module psram_sleep_seq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_zz_n,
  input logic          mem_ce_n,
  input logic [AW-1:0] mem_addr,
  input logic          dq_hiz,
  input logic          acc_gnt,
  input logic [1:0]    status,
  input logic          lost
);
  // R3
  zz_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_zz_n |-> mem_ce_n);
  // R8
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0) |-> (dq_hiz && mem_ce_n));
  // R7
  gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (status == 2'd0));
  // R5
  lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> lost);
  // R5
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> lost);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_zz_n |=> $stable(mem_addr));
endmodule

bind psram_sleep_seq psram_sleep_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_zz_n(mem_zz_n), .mem_ce_n(mem_ce_n),
  .mem_addr(mem_addr), .dq_hiz(dq_hiz), .acc_gnt(acc_gnt),
  .status(status), .lost(lost)
);

// File: tb/psram_sleep_seq_tb.sv
module psram_sleep_seq_tb;
  localparam int AW = 18;
  localparam logic [AW-1:0] DEF = 18'h00010;
  localparam int SU = 2, PW = 3, HD = 2, PX = 4, DX = 40;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_cfg = 0;
  logic acc_req = 0, acc_ce_n = 1;
  logic [AW-1:0] acc_addr = 0;
  logic cmd_ready, acc_gnt, mem_ce_n, mem_zz_n, dq_hiz, page_en, lost;
  logic [AW-1:0] mem_addr, cfg_shadow;
  logic [1:0] status;

  always #2 clk = ~clk;

  psram_sleep_seq #(.AW(AW), .CFG_DEFAULT(DEF), .SETUP_CYC(SU), .PULSE_CYC(PW),
    .HOLD_CYC(HD), .PAR_EXIT_CYC(PX), .DPD_EXIT_CYC(DX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cfg(cmd_cfg), .cmd_ready(cmd_ready), .acc_req(acc_req),
    .acc_ce_n(acc_ce_n), .acc_addr(acc_addr), .acc_gnt(acc_gnt),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_zz_n(mem_zz_n),
    .dq_hiz(dq_hiz), .page_en(page_en), .cfg_shadow(cfg_shadow),
    .status(status), .lost(lost));

  typedef struct { bit chk_addr; logic [AW-1:0] addr; int len; string req; } pulse_t;
  pulse_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: measures every low pulse on the sleep pin
  logic prev_zz = 1;
  logic [AW-1:0] prev_addr = 0, first_addr = 0;
  int len = 0;
  bit addr_ok = 1, ce_ok = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_zz_n) begin
        if (prev_zz) begin
          len = 1; first_addr = mem_addr;
          addr_ok = (prev_addr == mem_addr); ce_ok = mem_ce_n;
        end else begin
          len++; addr_ok &= (mem_addr == first_addr); ce_ok &= mem_ce_n;
        end
      end else if (!prev_zz) begin
        pulse_t e;
        addr_ok &= (mem_addr == first_addr);
        if (exp_q.size() == 0) chk(0, "R10 unexpected pulse", len, 0);
        else begin
          e = exp_q.pop_front();
          chk(len == e.len, {e.req, " pulse length"}, len, e.len);
          chk(ce_ok, "R3 ce high in pulse", ce_ok, 1);
          if (e.chk_addr) begin
            chk(addr_ok, "R4 address setup/hold stable", addr_ok, 1);
            chk(first_addr == e.addr, "R4 address value", first_addr, e.addr);
          end
        end
      end
      prev_zz = mem_zz_n;
      prev_addr = mem_addr;
    end
  end

  task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] cfg);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_cfg = cfg;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic busy_len(output int c, output bit bad);
    c = 0; bad = 0;
    while (status == 2'd3) begin
      c++;
      if (acc_gnt || cmd_ready) bad = 1;
      @(negedge clk);
    end
  endtask

  task automatic load(input logic [AW-1:0] v);
    int c; bit bad;
    pulse_t e;
    e.chk_addr = 1; e.addr = v; e.len = PW; e.req = "R4";
    exp_q.push_back(e);
    do_cmd(2'd0, v);
    busy_len(c, bad);
    chk(c == SU + PW + HD, "R4 load busy length", c, SU + PW + HD);
    chk(!bad, "R9 no ready or grant while busy", bad, 0);
    chk(cfg_shadow == v, "R2 shadow updated", cfg_shadow, v);
    chk(page_en == v[7], "R2 page flag", page_en, v[7]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c; bit bad;
    pulse_t e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 0, "R1 status", status, 0);
    chk(mem_zz_n == 1, "R1 sleep pin", mem_zz_n, 1);
    chk(lost == 0, "R1 lost", lost, 0);
    chk(dq_hiz == 0, "R1 hiz", dq_hiz, 0);
    chk(cfg_shadow == DEF, "R1 shadow default", cfg_shadow, DEF);
    chk(page_en == 0, "R2 default page flag", page_en, 0);

    acc_req = 1; acc_ce_n = 0; acc_addr = 18'h2A5A5; #1;
    chk(acc_gnt == 1, "R7 grant idle", acc_gnt, 1);
    chk(mem_addr == 18'h2A5A5, "R7 addr pass", mem_addr, 18'h2A5A5);
    chk(mem_ce_n == 0, "R7 ce pass", mem_ce_n, 0);
    cmd_valid = 1; cmd_op = 2'd3; #1;
    chk(acc_gnt == 0, "R7 command blocks grant", acc_gnt, 1'b0);
    @(negedge clk); cmd_valid = 0; #1;
    chk(status == 0 && mem_zz_n, "R10 op none ignored", status, 0);

    load(18'h00090);

    // partial refresh sleep, with ignored load and sleep inside it
    e.chk_addr = 0; e.addr = 0; e.len = 6; e.req = "R5 partial";
    exp_q.push_back(e);
    do_cmd(2'd1, 0);
    chk(status == 1, "R5 partial status", status, 1);
    chk(dq_hiz == 1, "R8 hiz asleep", dq_hiz, 1);
    chk(mem_ce_n == 1, "R3 ce forced high", mem_ce_n, 1);
    chk(acc_gnt == 0, "R7 no grant asleep", acc_gnt, 0);
    do_cmd(2'd0, 18'h3FFFF);
    chk(status == 1 && cfg_shadow == 18'h00090, "R10 load ignored asleep", cfg_shadow, 18'h00090);
    do_cmd(2'd1, 0);
    chk(status == 1 && !mem_zz_n, "R10 sleep ignored asleep", status, 1);
    do_cmd(2'd2, 0);
    busy_len(c, bad);
    chk(c == PX, "R6 partial exit wait", c, PX);
    chk(lost == 0, "R5 no loss after partial", lost, 0);
    chk(cfg_shadow == 18'h00090, "R6 shadow kept after partial", cfg_shadow, 18'h00090);

    load(18'h00005);

    e.chk_addr = 0; e.addr = 0; e.len = 5; e.req = "R5 deep";
    exp_q.push_back(e);
    do_cmd(2'd1, 0);
    chk(status == 2, "R5 deep status", status, 2);
    chk(lost == 1, "R5 lost set", lost, 1);
    chk(dq_hiz == 1, "R8 hiz deep", dq_hiz, 1);
    repeat (3) @(negedge clk);
    do_cmd(2'd2, 0);
    busy_len(c, bad);
    chk(c == DX, "R6 deep exit wait", c, DX);
    chk(cfg_shadow == DEF, "R6 default reloaded", cfg_shadow, DEF);
    chk(lost == 1, "R5 lost sticky", lost, 1);
    chk(status == 0 && acc_gnt, "R7 grant after exit", status, 0);

    do_cmd(2'd2, 0);
    chk(status == 0 && mem_zz_n, "R10 wake ignored active", status, 0);
    chk(cmd_ready == 1, "R9 ready when active", cmd_ready, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all pulses seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule